// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block runs on the host side of a parallel NOR flash and decides when a program or erase that is already under way has finished. After a start pulse it reads the device's 8-bit status byte over a simple read port, one read at a time. It takes each pair of reads and compares the toggle bit (bit 6) between the two. A toggle bit that holds its value means the operation is over. A toggle bit that is still moving is judged against the timeout flag (bit 5) from the second read of that pair.

The flag may rise in the same cycle that the toggle bit stops. For this reason a raised flag does not cause a failure at once. The block first takes one more pair of reads. Only when the toggle bit still moves in that pair does it report failure and send a one-cycle reset-command request to the command sequencer. That sequencer returns the device to array reads. When the toggle bit moves and the flag is low, the block keeps polling with fresh pairs.

An abort input drops polling at any time. The next start always begins with a new first read. A read that was left in flight by an abort is still waited for and then discarded.

Top module: `toggle_poller`

## Requirements
- R1: During reset and in the first cycle after it, busy, done, fail, reset_cmd_req and rd_req are all low.
- R2: A start sampled while idle raises busy in the next cycle and begins a new pair of reads. A start sampled while busy has no effect.
- R3: At most one read is outstanding. rd_req is never high while an earlier request has not yet had its rd_vld. A response that belongs to a read abandoned by abort is discarded and is not used as status.
- R4: Each verdict uses exactly two consecutive reads. If bit 6 of the second read equals bit 6 of the first, done pulses, and busy is low from that same cycle.
- R5: If bit 6 differs and bit 5 of the second read is 0, no pulse is issued and a new pair of reads starts as a fresh first pair.
- R6: If bit 6 differs in a first pair and bit 5 of its second read is 1, one more pair is read. If bit 6 is steady in that pair, done pulses.
- R7: If bit 6 still differs in that confirming pair, fail and reset_cmd_req pulse together in the same cycle, and busy falls. The value of bit 5 in that pair does not matter.
- R8: An abort sampled in any cycle leaves busy, done, fail and rd_req low in the next cycle. The next start begins from a first pair, with no confirming state carried over.
- R9: done, fail and reset_cmd_req are single-cycle pulses. done and fail never occur together, and each operation ends with exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (honoured only when idle) |
| abort | input | 1 | Abandon polling and return to idle |
| rd_req | output | 1 | One-cycle status read request |
| rd_vld | input | 1 | Read response valid |
| rd_data | input | DATA_W | Status byte, sampled when rd_vld is high |
| busy | output | 1 | High from start until done, fail or abort |
| done | output | 1 | Pulse: operation completed |
| fail | output | 1 | Pulse: operation failed |
| reset_cmd_req | output | 1 | Pulse: ask the command port to issue a reset command |

## Verification
The bench aims at the case where the timeout flag rises while the toggle bit is still moving and the toggle bit then stops in the confirming pair. A design that fails on the first raised flag reports fail here instead of done. It also aborts in the middle of a confirming pair and restarts with a sequence that toggles with the flag low. A design that keeps the confirming state would then report fail on the first pair. An abort in the same cycle as a request is followed by a late response. A poller that takes in that stale byte, or that issues a new request before the response arrives, ends up with the wrong number of reads. Random sequences with random response delays exercise the pair counting. Each one is checked for outcome and read count.

// File: rtl/tbp_pkg.sv
// Package: shared types for the toggle-bit poller.
// Assumes nothing beyond SystemVerilog enum support.
package tbp_pkg;
    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;

    // Outcome of comparing one pair of status reads
    typedef enum logic [1:0] {
        VD_DONE    = 2'd0,
        VD_FAIL    = 2'd1,
        VD_CONFIRM = 2'd2,
        VD_AGAIN   = 2'd3
    } verdict_e;
endpackage

// File: rtl/tbp_rd_port.sv
// Module: tbp_rd_port
// Read-port guard. It passes a read request out only when no earlier read is
// in flight. It tracks that in-flight read and marks it stale when an abort
// arrives, so its late response is swallowed.
// Assumes every request is eventually answered by exactly one rd_vld.
module tbp_rd_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_rd,
    input  logic              abort,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_byte
);
    logic in_flight;
    logic stale;
    logic unused_ok;

    // Request goes out only when the port is free
    assign rd_req   = want_rd && !in_flight;
    // A response counts only for a live, non-stale read
    assign rsp_ok   = rd_vld && in_flight && !stale;
    assign rsp_byte = rd_data;
    assign unused_ok = rsp_ok;

    // Track the single outstanding read and its stale mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= 1'b0;
            stale     <= 1'b0;
        end else if (rd_req) begin
            in_flight <= 1'b1;
            stale     <= abort;
        end else if (rd_vld && in_flight) begin
            in_flight <= 1'b0;
            stale     <= 1'b0;
        end else if (abort && in_flight) begin
            stale     <= 1'b1;
        end
    end
endmodule

// File: rtl/tbp_judge.sv
// Module: tbp_judge
// Pure combinational verdict for one pair of status reads. It compares the
// stored toggle bit with the current one and looks at the timeout flag.
// Assumes the caller only uses the verdict on the second read of a pair.
module tbp_judge
    import tbp_pkg::*;
(
    input  logic     first_tgl,
    input  logic     tgl_now,
    input  logic     tmo_now,
    input  logic     confirm,
    output verdict_e verdict
);
    // Decide the result of the pair
    always_comb begin
        if (first_tgl == tgl_now) begin
            verdict = VD_DONE;
        end else if (confirm) begin
            verdict = VD_FAIL;
        end else if (tmo_now) begin
            verdict = VD_CONFIRM;
        end else begin
            verdict = VD_AGAIN;
        end
    end
endmodule

// File: rtl/tbp_seq.sv
// Module: tbp_seq
// Polling sequencer. It walks through request/wait for the two reads of
// each pair, stores the first toggle bit, acts on the judge's verdict and
// drives the registered status pulses.
// Assumes rd_fire is high only in ST_ISSUE and rsp_ok only in ST_WAIT.
module tbp_seq
    import tbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     abort,
    input  logic     rd_fire,
    input  logic     rsp_ok,
    input  logic     tgl_now,
    input  verdict_e verdict,
    output logic     want_rd,
    output logic     first_tgl,
    output logic     confirm,
    output logic     busy,
    output logic     done,
    output logic     fail,
    output logic     reset_cmd_req
);
    seq_st_e state;
    logic    second;

    // Ask for a read whenever the sequencer is in the issue state
    assign want_rd = (state == ST_ISSUE);

    // Main sequencing and status pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            second        <= 1'b0;
            first_tgl     <= 1'b0;
            confirm       <= 1'b0;
            busy          <= 1'b0;
            done          <= 1'b0;
            fail          <= 1'b0;
            reset_cmd_req <= 1'b0;
        end else begin
            done          <= 1'b0;
            fail          <= 1'b0;
            reset_cmd_req <= 1'b0;
            if (abort) begin
                state   <= ST_IDLE;
                second  <= 1'b0;
                confirm <= 1'b0;
                busy    <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            state   <= ST_ISSUE;
                            second  <= 1'b0;
                            confirm <= 1'b0;
                            busy    <= 1'b1;
                        end
                    end
                    ST_ISSUE: begin
                        if (rd_fire) begin
                            state <= ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (rsp_ok) begin
                            if (!second) begin
                                first_tgl <= tgl_now;
                                second    <= 1'b1;
                                state     <= ST_ISSUE;
                            end else begin
                                second <= 1'b0;
                                case (verdict)
                                    VD_DONE: begin
                                        done  <= 1'b1;
                                        busy  <= 1'b0;
                                        state <= ST_IDLE;
                                    end
                                    VD_FAIL: begin
                                        fail          <= 1'b1;
                                        reset_cmd_req <= 1'b1;
                                        busy          <= 1'b0;
                                        state         <= ST_IDLE;
                                    end
                                    VD_CONFIRM: begin
                                        confirm <= 1'b1;
                                        state   <= ST_ISSUE;
                                    end
                                    default: begin
                                        confirm <= 1'b0;
                                        state   <= ST_ISSUE;
                                    end
                                endcase
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/toggle_poller.sv
// Module: toggle_poller (top)
// Toggle-bit completion poller for a parallel NOR flash. It joins the read
// port guard, the sequencer and the pair judge together.
// Assumes a status byte with the toggle bit at TGL_BIT and the timeout flag
// at TMO_BIT, and a responder that answers every request once.
module toggle_poller
    import tbp_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TGL_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    output logic              rd_req,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              reset_cmd_req
);
    logic              want_rd;
    logic              rsp_ok;
    logic [DATA_W-1:0] rsp_byte;
    logic              first_tgl;
    logic              confirm;
    verdict_e          verdict;
    logic              unused_bits;

    // Only the two flag bits are used; fold the rest away
    assign unused_bits = ^rsp_byte;

    tbp_rd_port #(.DATA_W(DATA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_rd  (want_rd),
        .abort    (abort),
        .rd_vld   (rd_vld),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rsp_ok   (rsp_ok),
        .rsp_byte (rsp_byte)
    );

    tbp_judge u_judge (
        .first_tgl (first_tgl),
        .tgl_now   (rsp_byte[TGL_BIT]),
        .tmo_now   (rsp_byte[TMO_BIT]),
        .confirm   (confirm),
        .verdict   (verdict)
    );

    tbp_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .abort         (abort),
        .rd_fire       (rd_req),
        .rsp_ok        (rsp_ok),
        .tgl_now       (rsp_byte[TGL_BIT]),
        .verdict       (verdict),
        .want_rd       (want_rd),
        .first_tgl     (first_tgl),
        .confirm       (confirm),
        .busy          (busy),
        .done          (done),
        .fail          (fail),
        .reset_cmd_req (reset_cmd_req)
    );
endmodule

// File: rtl/tbp_chk.sv
// Module: tbp_chk
// Port-level protocol checker for toggle_poller, attached with bind.
// Assumes the environment answers each request with one rd_vld.
module tbp_chk (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic rd_req,
    input logic rd_vld,
    input logic busy,
    input logic done,
    input logic fail,
    input logic reset_cmd_req
);
    logic pend;

    // Independent record of whether a read is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (rd_req) pend <= 1'b1;
        else if (rd_vld) pend <= 1'b0;
    end

    a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !pend);
    a_r2_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);
    a_r4_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_fail_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> reset_cmd_req);
    a_r7_reset_only_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd_req |-> fail);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    a_r8_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !done && !fail && !rd_req));
endmodule

bind toggle_poller tbp_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .rd_req        (rd_req),
    .rd_vld        (rd_vld),
    .busy          (busy),
    .done          (done),
    .fail          (fail),
    .reset_cmd_req (reset_cmd_req)
);

// File: tb/test_toggle_poller.sv
// Bench for toggle_poller: directed corner cases plus seeded random
// status sequences, scored against a reference function.
module test_toggle_poller;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       abort = 1'b0;
    logic       rd_vld = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       rd_req, busy, done, fail, reset_cmd_req;
    logic [7:0] seq_q[$];
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    toggle_poller i_toggle_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .rd_req(rd_req), .rd_vld(rd_vld), .rd_data(rd_data),
        .busy(busy), .done(done), .fail(fail), .reset_cmd_req(reset_cmd_req)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference: outcome 0 = done, 1 = fail, 2 = undecided; reads consumed
    function automatic void ref_model(input logic [7:0] s[$], output int outc, output int nrd);
        bit cf = 1'b0;
        outc = 2;
        nrd  = 0;
        for (int i = 0; i + 1 < s.size(); i += 2) begin
            nrd += 2;
            if (s[i][6] == s[i+1][6]) begin outc = 0; return; end
            if (cf) begin outc = 1; return; end
            if (s[i+1][5]) cf = 1'b1;
        end
    endfunction

    task automatic run_op(input string req, input int abort_req, input int dup_at);
        int exp_out, exp_rd;
        int got_done = 0, got_fail = 0, got_rst = 0, reads = 0, nreq = 0, cyc = 0, dly = 0;
        bit pend = 1'b0, fin = 1'b0, aborted = 1'b0;
        ref_model(seq_q, exp_out, exp_rd);
        @(negedge clk);
        start = 1'b1;
        while (!fin && !aborted && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            start  = (cyc == dup_at) ? 1'b1 : 1'b0;
            rd_vld = 1'b0;
            if (cyc == 1) chk(busy, 1, "R2", "busy after start");
            if (done) begin got_done++; fin = 1'b1; end
            if (fail) begin got_fail++; fin = 1'b1; end
            if (reset_cmd_req) got_rst++;
            if (pend) begin
                if (dly == 0) begin
                    rd_vld  = 1'b1;
                    rd_data = (seq_q.size() > 0) ? seq_q.pop_front() : 8'h00;
                    reads++;
                    pend = 1'b0;
                end else dly--;
            end else if (rd_req) begin
                nreq++;
                pend = 1'b1;
                dly  = $urandom % 4;
                if (nreq == abort_req) begin
                    abort   = 1'b1;
                    aborted = 1'b1;
                end
            end
        end
        start = 1'b0;
        chk(cyc < 4000, 1, req, "operation finished in time");
        if (aborted) begin
            @(negedge clk);
            abort = 1'b0;
            chk(busy, 0, "R8", "busy after abort");
            chk(rd_req, 0, "R8", "rd_req after abort");
            chk(done | fail, 0, "R8", "pulse after abort");
            repeat (2) @(negedge clk);
            rd_vld = 1'b1; rd_data = 8'hE0;
            @(negedge clk);
            rd_vld = 1'b0;
            chk(done | fail | busy, 0, "R3", "stale response ignored");
            seq_q.delete();
        end else begin
            @(negedge clk);
            chk(got_done, (exp_out == 0) ? 1 : 0, req, "done count");
            chk(got_fail, (exp_out == 1) ? 1 : 0, req, "fail count");
            chk(got_rst, got_fail, "R7", "reset request matches fail");
            chk(reads, exp_rd, req, "reads consumed");
            chk(done | fail | reset_cmd_req, 0, "R9", "pulse one cycle");
            chk(busy, 0, "R4", "busy low after verdict");
        end
    endtask

    task automatic load(input logic [7:0] a[]);
        seq_q.delete();
        foreach (a[i]) seq_q.push_back(a[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, c;
        bit cf, tog;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(busy | done | fail | reset_cmd_req | rd_req, 0, "R1", "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy | done | fail | reset_cmd_req | rd_req, 0, "R1", "outputs after reset");

        load('{8'h00, 8'h00});                         run_op("R4", 0, 0);
        load('{8'h40, 8'h40});                         run_op("R4", 0, 0);
        load('{8'h00, 8'h40, 8'h40, 8'h40});           run_op("R5", 0, 0);
        load('{8'h00, 8'h60, 8'h20, 8'h20});           run_op("R6", 0, 0);
        load('{8'h00, 8'h60, 8'h00, 8'h40});           run_op("R7", 0, 0);
        load('{8'h00, 8'h60, 8'h40, 8'h00});           run_op("R7", 0, 0);
        load('{8'h40, 8'h00, 8'h00, 8'h60, 8'h20, 8'h20}); run_op("R6", 0, 0);
        load('{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00}); run_op("R2", 0, 3);
        // Abort inside a confirming pair, then restart
        load('{8'h00, 8'h60, 8'h00});                  run_op("R8", 3, 0);
        load('{8'h00, 8'h40, 8'h40, 8'h40});           run_op("R8", 0, 0);
        // Abort on the very first request, stale byte must not count
        load('{8'h00});                                run_op("R3", 1, 0);
        load('{8'h40, 8'h40});                         run_op("R3", 0, 0);

        for (int n = 0; n < 40; n++) begin
            seq_q.delete();
            cf = 1'b0;
            for (int p = 0; p < 8; p++) begin
                a   = 8'($urandom);
                c   = 8'($urandom);
                tog = (p < 7) && (($urandom % 3) != 0);
                c[6] = a[6] ^ tog;
                c[5] = (($urandom % 10) < 3);
                seq_q.push_back(a);
                seq_q.push_back(c);
                if (!tog || cf) break;
                if (c[5]) cf = 1'b1;
            end
            run_op("R5", 0, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule